// File: doc/BRIEF.md
# FIFO-driven I2C master sequencer

This block is the transfer engine of an I2C controller. Software pushes a 9-bit address command into a transmit queue, then the bytes to write. It starts the bus with one control write. The engine then produces START, the address byte, data bytes, acknowledge bits and STOP on open-drain SCL and SDA. Each output pin means "pull the line low". Received bytes go into a receive queue. The quarter-bit pacing strobe comes from a separate clock-period block. Event pulses go to a separate interrupt block.

A transfer that ends without STOP leaves the bus held with SCL low. If the next entry at the head of the transmit queue is an address command, the engine issues a repeated START for it by itself. A receive byte count lets the engine NACK the last byte of a read without software help. With a count of zero, reading goes on until software requests a NACK. Both queues use valid/ready handshakes. A push is taken on a clock edge where valid and ready are both high, and ready is low while the queue is full. A pop is taken on an edge where valid and ready are both high, and valid is low while the queue is empty.

Top module: `i2c_fifo_master`

## Requirements
- R1: A transmit entry with bit 8 set is an address command: bits 7:1 are the target address and bit 0 is the read flag (1 = read). A control write has four bits: bit 3 = master enable, bit 2 = request START, bit 1 = request STOP, bit 0 = NACK the next received byte. A control write with bits 3 and 2 set starts a transfer once an address command is at the head of the transmit queue.
- R2: Each queue holds 8 entries. After 8 pushes the transmit side drops ready and reports not-full = 0, and the count never exceeds the depth.
- R3: Address and data bytes go out MSB first. SDA changes only while the engine holds SCL low, and the target's ACK lets the transfer continue.
- R4: With a nonzero receive count N (1 to 255), a read collects N bytes. The engine ACKs every byte except the last, which it NACKs, and then issues STOP if one is requested.
- R5: With a receive count of zero, a read goes on with ACKs until a control write sets bit 0. The next read byte started after that write is NACKed.
- R6: While the bus is held after a transfer with no STOP, an address command at the head of the transmit queue produces a repeated START with no further control write.
- R7: A high SDA in the acknowledge slot after a byte the engine sent gives a one-cycle no-ACK pulse, and the engine then issues STOP.
- R8: If SDA reads low while the engine releases it during a sent bit, a one-cycle arbitration-lost pulse fires. The engine releases both lines and returns to idle.
- R9: Bus-busy is set when SDA falls while SCL is high (START). It is cleared, and STOP-seen is set, when SDA rises while SCL is high. STOP-seen is cleared by the next START.
- R10: When the transmit queue runs empty during a write with no STOP requested, the engine holds SCL low. It resumes when more data is pushed.
- R11: Three strobes act in one cycle: one empties the transmit queue, one empties the receive queue, and the third returns the engine to idle with both lines released.
- R12: The engine does not start a read byte while the receive queue is full. It holds SCL low until an entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Quarter-bit pacing strobe |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Control bits: enable, START, STOP, NACK-next |
| rx_count | input | CNT_W | Receive byte count, sampled when an address command is loaded |
| tx_valid | input | 1 | Transmit push valid |
| tx_ready | output | 1 | Transmit queue can take an entry |
| tx_data | input | 9 | Transmit entry (bit 8 = address command) |
| rx_valid | output | 1 | Receive queue has a byte |
| rx_ready | input | 1 | Receive pop |
| rx_data | output | 8 | Oldest received byte |
| clr_tx | input | 1 | Empty the transmit queue |
| clr_rx | input | 1 | Empty the receive queue |
| bus_reset | input | 1 | Force the engine idle |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| ev_noack | output | 1 | No-ACK pulse |
| ev_arb_lost | output | 1 | Arbitration-lost pulse |
| st_dev_busy | output | 1 | Engine not idle |
| st_stop_seen | output | 1 | STOP detected on the bus |
| st_bus_busy | output | 1 | Bus between START and STOP |
| st_rx_full | output | 1 | Receive queue full |
| st_rx_nempty | output | 1 | Receive queue not empty |
| st_tx_nfull | output | 1 | Transmit queue not full |
| st_tx_empty | output | 1 | Transmit queue empty |

## Verification
The bench builds the block with its defaults: 8-entry queues and an 8-bit receive count. With these values a write of seven data bytes plus its command fills the transmit queue exactly. A ten-byte read overruns the receive queue, so the full-queue stall can be reached. A behavioural target on the wired-AND lines ACKs, returns counted read data and records the master's acknowledge bits. The bench can also hold SDA low to cause an arbitration loss.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_POS = BYTE_W;   // tag bit of a transmit entry
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_BIT, S_NEXT, S_RSTART, S_STOP
  } seq_state_t;
endpackage

// File: rtl/i2cseq_fifo.sv
module i2cseq_fifo #(
  parameter int W = 9,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;
  logic push, pop;

  assign full      = (cnt == FULL_CNT);
  assign in_ready  = !full;
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  // R2: occupancy never passes the depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
endmodule

// File: rtl/i2cseq_busmon.sv
module i2cseq_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy,
  output logic stop_seen
);
  logic scl_q, sda_q, start_det, stop_det;

  assign start_det = scl_in && scl_q && sda_q && !sda_in;
  assign stop_det  = scl_in && scl_q && !sda_q && sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; busy <= 1'b0; stop_seen <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_det) begin busy <= 1'b1; stop_seen <= 1'b0; end
      else if (stop_det) begin busy <= 1'b0; stop_seen <= 1'b1; end
    end
  end

  // R9: a STOP never leaves the bus flagged busy
  p_stop_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen && !$past(stop_seen) |-> !busy);
endmodule

// File: rtl/i2c_fifo_master.sv
module i2c_fifo_master
  import i2cseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_we,
  input  logic [3:0]       ctrl_wdata,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [8:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  input  logic             clr_tx,
  input  logic             clr_rx,
  input  logic             bus_reset,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             ev_noack,
  output logic             ev_arb_lost,
  output logic             st_dev_busy,
  output logic             st_stop_seen,
  output logic             st_bus_busy,
  output logic             st_rx_full,
  output logic             st_rx_nempty,
  output logic             st_tx_nfull,
  output logic             st_tx_empty
);
  localparam int TXW = BYTE_W + 1;

  seq_state_t state;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0] remaining;
  logic master_en, start_pend, stop_pend, nack_pend;
  logic rd_mode, is_addr, cnt_mode, rx_more, ack_bit, peer_nak;
  logic scl_low, sda_low;

  logic [TXW-1:0] tx_head;
  logic tx_have, tx_pop, tx_full, rx_full, rx_in_ready, rx_push;
  logic adv, receiving, go, load_cmd, byte_end;
  logic nxt_read, nxt_data, nxt_rs, nxt_stop, rd_busy;

  i2cseq_fifo #(.W(TXW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .clr(clr_tx), .in_valid(tx_valid), .in_ready(tx_ready),
    .in_data(tx_data), .out_valid(tx_have), .out_ready(tx_pop),
    .out_data(tx_head), .full(tx_full));

  i2cseq_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .clr(clr_rx), .in_valid(rx_push), .in_ready(rx_in_ready),
    .in_data(shreg), .out_valid(rx_valid), .out_ready(rx_ready),
    .out_data(rx_data), .full(rx_full));

  i2cseq_busmon u_mon (
    .clk, .rst_n, .scl_in, .sda_in, .busy(st_bus_busy), .stop_seen(st_stop_seen));

  // sequencing decisions
  always_comb begin
    adv       = tick && !(q == 2'd2 && !scl_in);   // wait out clock stretching
    receiving = rd_mode && !is_addr;
    rd_busy   = rd_mode && rx_more;
    go        = (state == S_IDLE) && master_en && start_pend && tx_have && tx_head[CMD_POS];
    load_cmd  = adv && (q == 2'd3) && (state == S_START || state == S_RSTART);
    nxt_read  = (state == S_NEXT) && rd_busy && !rx_full;
    nxt_rs    = (state == S_NEXT) && !rd_busy && tx_have && tx_head[CMD_POS];
    nxt_data  = (state == S_NEXT) && !rd_busy && tx_have && !tx_head[CMD_POS] && !rd_mode;
    nxt_stop  = (state == S_NEXT) && !rd_busy && !nxt_rs && !nxt_data && stop_pend;
    byte_end  = (state == S_BIT) && adv && (q == 2'd3) && (bitn == 4'd8);
    rx_push   = byte_end && receiving;
    tx_pop    = load_cmd || nxt_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; q <= '0; bitn <= '0; shreg <= '0; remaining <= '0;
      master_en <= 1'b0; start_pend <= 1'b0; stop_pend <= 1'b0; nack_pend <= 1'b0;
      rd_mode <= 1'b0; is_addr <= 1'b0; cnt_mode <= 1'b0; rx_more <= 1'b0;
      ack_bit <= 1'b0; peer_nak <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0;
      ev_noack <= 1'b0; ev_arb_lost <= 1'b0;
    end else begin
      ev_noack <= 1'b0;
      ev_arb_lost <= 1'b0;
      if (ctrl_we) begin
        master_en <= ctrl_wdata[3];
        if (ctrl_wdata[2]) start_pend <= 1'b1;
        if (ctrl_wdata[1]) stop_pend <= 1'b1;
        if (ctrl_wdata[0]) nack_pend <= 1'b1;
      end
      if (bus_reset) begin
        state <= S_IDLE; q <= '0; scl_low <= 1'b0; sda_low <= 1'b0; rx_more <= 1'b0;
        start_pend <= 1'b0; stop_pend <= 1'b0; nack_pend <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: begin
            scl_low <= 1'b0; sda_low <= 1'b0; q <= '0;
            if (go) state <= S_START;
          end
          S_START, S_RSTART: if (adv) begin
            q <= q + 2'd1;
            case (q)
              2'd0: if (state == S_RSTART) sda_low <= 1'b0;
              2'd1: if (state == S_START) sda_low <= 1'b1; else scl_low <= 1'b0;
              2'd2: if (state == S_START) scl_low <= 1'b1; else sda_low <= 1'b1;
              default: scl_low <= 1'b1;
            endcase
          end
          S_BIT: if (adv) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_low <= (bitn == 4'd8) ? (receiving && !ack_bit)
                                               : (!receiving && !shreg[BYTE_W-1]);
              2'd1: scl_low <= 1'b0;
              2'd2: if (bitn != 4'd8) begin
                if (!receiving && shreg[BYTE_W-1] && !sda_in) begin
                  ev_arb_lost <= 1'b1; state <= S_IDLE; q <= '0;
                  scl_low <= 1'b0; sda_low <= 1'b0;
                  start_pend <= 1'b0; stop_pend <= 1'b0;
                end else shreg <= {shreg[BYTE_W-2:0], sda_in};
              end else peer_nak <= sda_in;
              default: begin
                scl_low <= 1'b1;
                if (bitn != 4'd8) bitn <= bitn + 4'd1;
                else begin
                  is_addr <= 1'b0;
                  state <= S_NEXT;
                  if (!receiving && peer_nak) begin
                    ev_noack <= 1'b1; state <= S_STOP; rx_more <= 1'b0;
                  end else if (is_addr) rx_more <= rd_mode;
                  else if (receiving) rx_more <= !ack_bit;
                end
              end
            endcase
          end
          S_NEXT: begin
            if (nxt_read) begin
              bitn <= '0; q <= '0; state <= S_BIT;
              if (cnt_mode) begin
                ack_bit <= (remaining == CNT_W'(1));
                remaining <= remaining - 1'b1;
              end else begin
                ack_bit <= nack_pend;
                if (nack_pend) nack_pend <= 1'b0;
              end
            end else if (nxt_data) begin
              shreg <= tx_head[BYTE_W-1:0]; bitn <= '0; q <= '0; state <= S_BIT;
            end else if (nxt_rs) begin
              state <= S_RSTART; q <= '0;
            end else if (nxt_stop) begin
              state <= S_STOP; q <= '0;
            end
          end
          S_STOP: if (adv) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: begin state <= S_IDLE; stop_pend <= 1'b0; start_pend <= 1'b0; end
            endcase
          end
          default: state <= S_IDLE;
        endcase
        if (load_cmd) begin
          shreg <= tx_head[BYTE_W-1:0]; is_addr <= 1'b1; rd_mode <= tx_head[0];
          remaining <= rx_count; cnt_mode <= (rx_count != '0); rx_more <= 1'b0;
          bitn <= '0; q <= '0; state <= S_BIT; start_pend <= 1'b0;
        end
      end
    end
  end

  assign scl_oe       = scl_low;
  assign sda_oe       = sda_low;
  assign st_dev_busy  = (state != S_IDLE);
  assign st_rx_full   = rx_full;
  assign st_rx_nempty = rx_valid;
  assign st_tx_nfull  = !tx_full;
  assign st_tx_empty  = !tx_have;

  // R3: inside a byte, SDA moves only while SCL is pulled low
  p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BIT && $past(state) == S_BIT && !$stable(sda_oe)) |-> scl_oe);
  // R7: a missing ACK is followed by the STOP sequence
  p_noack_to_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_noack |-> (state == S_STOP));
  // R8: arbitration loss leaves both lines released
  p_arb_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |-> (!scl_oe && !sda_oe && !st_dev_busy));
  // R12: a received byte always finds room
  p_rx_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_in_ready);
  // R2: nothing is taken from an empty transmit queue
  p_tx_pop_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_have);
endmodule

// File: tb/sim_i2c_fifo_master.sv
module sim_i2c_fifo_master;
  localparam logic [6:0] T_ADDR = 7'h2A;
  localparam logic [7:0] RD_BASE = 8'hA5;
  // vector: [15] read, [14:11] byte count, [7:0] first data byte
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 4'd1, 3'd0, 8'h3C}, {1'b0, 4'd3, 3'd0, 8'h80},
    {1'b0, 4'd7, 3'd0, 8'hF0}, {1'b1, 4'd1, 3'd0, 8'h00},
    {1'b1, 4'd4, 3'd0, 8'h00}, {1'b1, 4'd8, 3'd0, 8'h00}};

  logic clk = 0, rst_n = 0, tick = 0;
  logic ctrl_we = 0; logic [3:0] ctrl_wdata = 0; logic [7:0] rx_count = 0;
  logic tx_valid = 0, rx_ready = 0, clr_tx = 0, clr_rx = 0, bus_reset = 0;
  logic [8:0] tx_data = 0;
  logic tx_ready, rx_valid, scl_oe, sda_oe, ev_noack, ev_arb_lost;
  logic st_dev_busy, st_stop_seen, st_bus_busy, st_rx_full, st_rx_nempty, st_tx_nfull, st_tx_empty;
  logic [7:0] rx_data;
  logic t_low = 0, ext_low = 0, t_ack_en = 1;
  wire scl_w = !scl_oe;
  wire sda_w = !sda_oe && !t_low && !ext_low;

  int errors = 0, checks = 0, n_noack = 0, n_arb = 0;

  i2c_fifo_master u0 (.clk, .rst_n, .tick, .ctrl_we, .ctrl_wdata, .rx_count,
    .tx_valid, .tx_ready, .tx_data, .rx_valid, .rx_ready, .rx_data,
    .clr_tx, .clr_rx, .bus_reset, .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe, .sda_oe, .ev_noack, .ev_arb_lost, .st_dev_busy, .st_stop_seen,
    .st_bus_busy, .st_rx_full, .st_rx_nempty, .st_tx_nfull, .st_tx_empty);

  always #5 clk = !clk;
  always @(posedge clk) begin
    tick <= !tick;
    if (ev_noack) n_noack++;
    if (ev_arb_lost) n_arb++;
  end

  // behavioural target on the wired-AND lines
  int t_bit = 0, t_ridx = 0, t_widx = 0, t_starts = 0;
  bit t_fresh = 0, t_addr_ph = 0, t_rw = 0, t_match = 0;
  logic [7:0] t_sh = 0, t_seen_addr = 0, t_rbyte = 0;
  logic [7:0] t_wbuf [16];
  bit t_mack [16];

  always @(negedge sda_w) if (scl_w) begin
    t_fresh = 1; t_bit = 0; t_addr_ph = 1; t_low = 0; t_starts++;
  end
  always @(posedge sda_w) if (scl_w) begin t_match = 0; t_low = 0; end
  always @(posedge scl_w) begin
    if (t_bit < 8) t_sh = {t_sh[6:0], sda_w};
    else if (t_match && t_rw && !t_addr_ph) t_mack[t_ridx] = sda_w;
  end
  always @(negedge scl_w) begin
    if (t_fresh) t_fresh = 0;
    else if (t_bit == 7) begin
      t_bit = 8;
      if (t_addr_ph) begin
        t_seen_addr = t_sh; t_match = (t_sh[7:1] == T_ADDR); t_rw = t_sh[0];
        t_low = t_match && t_ack_en; t_ridx = 0;
      end else if (!t_rw) begin
        if (t_match) begin t_wbuf[t_widx] = t_sh; t_widx++; t_low = t_ack_en; end
      end else t_low = 0;
    end else if (t_bit == 8) begin
      t_bit = 0; t_low = 0;
      if (t_match && t_rw && (t_addr_ph || !t_mack[t_ridx])) begin
        if (!t_addr_ph) t_ridx++;
        t_rbyte = RD_BASE + 8'(t_ridx); t_low = !t_rbyte[7];
      end
      t_addr_ph = 0;
    end else begin
      t_bit++;
      if (t_match && t_rw && !t_addr_ph) t_low = !t_rbyte[7 - t_bit];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask
  task automatic ctrl(input logic [3:0] w);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = w; @(negedge clk); ctrl_we = 0;
  endtask
  task automatic push(input logic [8:0] d);
    @(negedge clk); tx_data = d; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 0;
  endtask
  task automatic pop(output logic [7:0] d);
    int n = 0;
    @(negedge clk);
    while (!rx_valid && n < 5000) begin @(negedge clk); n++; end
    d = rx_data; rx_ready = 1; @(negedge clk); rx_ready = 0;
  endtask
  task automatic wait_idle();
    int n = 0;
    repeat (4) @(negedge clk);
    while (st_dev_busy && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk(0, "engine hang", 1, 0);
  endtask
  task automatic strobe(input int which);
    @(negedge clk);
    if (which == 0) clr_tx = 1; else if (which == 1) clr_rx = 1; else bus_reset = 1;
    @(negedge clk); clr_tx = 0; clr_rx = 0; bus_reset = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int k, n0;
    repeat (4) @(negedge clk); rst_n = 1; @(negedge clk);
    chk(st_tx_empty && st_tx_nfull && !st_rx_nempty, "R2 reset queues", {st_tx_empty, st_tx_nfull, st_rx_nempty}, 3'b110);
    chk(!scl_oe && !sda_oe && !st_dev_busy && !st_bus_busy, "R9 reset lines", {scl_oe, sda_oe, st_dev_busy, st_bus_busy}, 0);

    // table of plain transfers
    for (int v = 0; v < 6; v++) begin
      int n = VEC[v][14:11];
      t_widx = 0;
      if (!VEC[v][15]) begin
        push({1'b1, T_ADDR, 1'b0});
        for (int i = 0; i < n; i++) push({1'b0, VEC[v][7:0] + 8'(i)});
        if (n == 7) begin @(negedge clk); chk(!st_tx_nfull && !tx_ready, "R2 full queue", st_tx_nfull, 0); end
        ctrl(4'b1110); wait_idle();
        chk(t_seen_addr == {T_ADDR, 1'b0}, "R1 address", t_seen_addr, {T_ADDR, 1'b0});
        chk(t_widx == n, "R3 byte count", t_widx, n);
        for (int i = 0; i < n; i++)
          chk(t_wbuf[i] == VEC[v][7:0] + 8'(i), "R3 data byte", t_wbuf[i], VEC[v][7:0] + 8'(i));
      end else begin
        rx_count = 8'(n);
        push({1'b1, T_ADDR, 1'b1});
        ctrl(4'b1110); wait_idle();
        for (int i = 0; i < n; i++) begin
          pop(d); chk(d == RD_BASE + 8'(i), "R4 read byte", d, RD_BASE + 8'(i));
          chk(t_mack[i] == (i == n - 1), "R4 ack pattern", t_mack[i], i == n - 1);
        end
      end
      chk(st_stop_seen && !st_bus_busy, "R9 stop seen", {st_stop_seen, st_bus_busy}, 2'b10);
    end

    // R6: write held open, then a read command causes a repeated START
    t_widx = 0; n0 = t_starts; rx_count = 2;
    push({1'b1, T_ADDR, 1'b0}); push(9'h05A);
    ctrl(4'b1100);
    push({1'b1, T_ADDR, 1'b1});
    ctrl(4'b1010); wait_idle();
    chk(t_starts == n0 + 2, "R6 start count", t_starts, n0 + 2);
    chk(t_wbuf[0] == 8'h5A, "R6 write byte", t_wbuf[0], 8'h5A);
    for (int i = 0; i < 2; i++) begin pop(d); chk(d == RD_BASE + 8'(i), "R6 read byte", d, RD_BASE + 8'(i)); end

    // R10: underflow stall
    t_widx = 0;
    push({1'b1, T_ADDR, 1'b0}); push(9'h011);
    ctrl(4'b1100);
    k = 0; while (t_widx < 1 && k < 5000) begin @(negedge clk); k++; end
    repeat (100) @(negedge clk);
    chk(scl_oe && st_dev_busy && st_bus_busy && t_widx == 1, "R10 stall", {scl_oe, st_dev_busy, st_bus_busy}, 3'b111);
    push(9'h022); ctrl(4'b1010); wait_idle();
    chk(t_widx == 2 && t_wbuf[1] == 8'h22, "R10 resume", t_wbuf[1], 8'h22);

    // R5: count zero, software NACK
    rx_count = 0;
    push({1'b1, T_ADDR, 1'b1}); ctrl(4'b1110);
    k = 0; while (!rx_valid && k < 5000) begin @(negedge clk); k++; end
    ctrl(4'b1001); wait_idle();
    k = 0;
    while (rx_valid) begin pop(d); chk(d == RD_BASE + 8'(k), "R5 read byte", d, RD_BASE + 8'(k)); k++; end
    chk(k >= 2, "R5 continues past first byte", k, 2);
    if (k >= 2) chk(t_mack[k-1] && !t_mack[k-2], "R5 nack on last only", {t_mack[k-1], t_mack[k-2]}, 2'b10);

    // R12: receive queue full stalls the read
    rx_count = 10;
    push({1'b1, T_ADDR, 1'b1}); ctrl(4'b1110);
    k = 0; while (!st_rx_full && k < 20000) begin @(negedge clk); k++; end
    repeat (200) @(negedge clk);
    chk(st_rx_full && scl_oe && st_dev_busy, "R12 full stall", {st_rx_full, scl_oe, st_dev_busy}, 3'b111);
    for (int i = 0; i < 10; i++) begin pop(d); chk(d == RD_BASE + 8'(i), "R12 read byte", d, RD_BASE + 8'(i)); end
    wait_idle();
    chk(t_mack[9] && !t_mack[8], "R12 last nack", t_mack[9], 1);

    // R7: wrong address gets no ACK; R11 transmit clear
    n0 = n_noack;
    push({1'b1, 7'h11, 1'b0}); push(9'h0AA);
    ctrl(4'b1110); wait_idle();
    chk(n_noack == n0 + 1, "R7 noack pulse", n_noack, n0 + 1);
    chk(st_stop_seen && !st_bus_busy, "R7 stop issued", st_stop_seen, 1);
    chk(!st_tx_empty, "R11 leftover before clear", st_tx_empty, 0);
    strobe(0); @(negedge clk);
    chk(st_tx_empty, "R11 tx clear", st_tx_empty, 1);

    // R8: arbitration loss
    n0 = n_arb;
    push({1'b1, T_ADDR, 1'b0}); push(9'h0AA);
    ctrl(4'b1110);
    k = 0; while (!scl_oe && k < 5000) begin @(negedge clk); k++; end
    ext_low = 1;
    k = 0; while (st_dev_busy && k < 5000) begin @(negedge clk); k++; end
    @(negedge clk);
    chk(n_arb == n0 + 1, "R8 arb pulse", n_arb, n0 + 1);
    chk(!scl_oe && !sda_oe && !st_dev_busy, "R8 released", {scl_oe, sda_oe, st_dev_busy}, 0);
    ext_low = 0; repeat (4) @(negedge clk);
    chk(st_stop_seen && !st_bus_busy, "R9 external stop", {st_stop_seen, st_bus_busy}, 2'b10);
    strobe(0);

    // R11: receive clear and bus reset
    rx_count = 2;
    push({1'b1, T_ADDR, 1'b1}); ctrl(4'b1110); wait_idle();
    chk(st_rx_nempty, "R11 rx holds data", st_rx_nempty, 1);
    strobe(1); @(negedge clk);
    chk(!st_rx_nempty, "R11 rx clear", st_rx_nempty, 0);
    push({1'b1, T_ADDR, 1'b0}); push(9'h0FF); push(9'h0FF);
    ctrl(4'b1110);
    repeat (100) @(negedge clk);
    chk(st_dev_busy, "R11 busy before reset", st_dev_busy, 1);
    strobe(2);
    chk(!scl_oe && !sda_oe && !st_dev_busy, "R11 bus reset", {scl_oe, sda_oe, st_dev_busy}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule